// File: doc/BRIEF.md
# I2C Register-Port Slave with Auto-Increment

This block lets an I2C master read and write a bank of 8-bit control registers. It oversamples SCL and SDA with the system clock and detects START and STOP conditions. It answers only to its own 7-bit device address. Whichever way the bus is driven, a single output asks for SDA to be pulled low. That output is meant for an external open-drain pad.

After the device address, a write transfer loads a pointer byte. Bit 7 of that byte is the auto-increment flag and bits 6:0 name a register. Each further byte in the write goes to the addressed register. A read transfer returns the register that the pointer names. The pointer keeps its value from one transfer to the next. Until the first pointer write after reset it names register 0x01. With the flag set, the pointer steps through successive registers as data moves. With the flag clear, every byte hits the same register.

The register bank is outside the block. It is reached through an address, a write-data bus, a one-cycle write strobe and a combinational read-data bus.

Top module: `i2c_regport`

## Requirements
- R1: An address byte equal to {6'b100110, addr_sel, rw} (sent MSB first, rw=1 for read) is acknowledged: sda_pull holds SDA low during the ninth SCL clock.
- R2: Any other address byte is not acknowledged. The slave then leaves SDA released and issues no write strobe until the next START.
- R3: In a write transfer, the first byte after the address is acknowledged and loaded into the pointer. Bit 7 is the increment flag and bits 6:0 are the register address.
- R4: Each later byte of a write transfer is acknowledged and produces exactly one single-cycle reg_wr strobe. The strobe carries the byte on reg_wdata, with reg_addr at the pointer.
- R5: In writes with the flag set, the pointer advances by one, modulo 128, after every data byte. With the flag clear it stays put.
- R6: A read transfer sends the register at the pointer, MSB first. The pointer keeps its last loaded value across transfers. SDA only changes while SCL is low.
- R7: After reset, the pointer is 0x01 with the increment flag clear. SDA is released and reg_wr is low.
- R8: In reads, each master ACK advances the pointer by one when the flag is set, so the next byte comes from the next register. With the flag clear, the same register is repeated.
- R9: A master NACK after a read byte ends the transfer. The slave keeps SDA released for any further clocks until the next START.
- R10: A repeated START at a byte boundary restarts address decoding without a STOP. A STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = drive SDA low, 0 = release |
| addr_sel | input | 1 | Strap that sets the device-address LSB |
| reg_addr | output | 7 | Register address (the pointer) |
| reg_wdata | output | 8 | Data for a register write |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Combinational read data for reg_addr |

## Verification
A corrupted pointer shows up at the ports within one byte, in one of two ways. A write strobe lands on the wrong register, which is visible in the bench's register model at the end of that transfer. Or a read byte differs from the expected register contents. A wrong protocol state shows up sooner, within one SCL period. It appears as a missing or spurious acknowledge, or as SDA held low where the master expects a released line. The bench compares every acknowledge bit and every read byte against its own model of the pointer and registers. It also compares the whole register bank after each write.

// File: rtl/i2crp_pkg.sv
// Shared types for the I2C register-port slave.
// Assumes 8-bit bus bytes and a 7-bit register pointer.
package i2crp_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } st_t;
endpackage

// File: rtl/i2crp_sync.sv
// Synchronises SCL and SDA into the clk domain and derives SCL edges plus
// START/STOP events. Assumes clk is many times faster than SCL and both lines
// pass through the same number of stages, so their order is kept.
module i2crp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains and one-cycle history, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_in};
            sda_p <= {sda_p[STAGES-2:0], sda_in};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    // Edge and bus-condition decode from the synchronised lines.
    always_comb begin
        scl_q     = scl_p[STAGES-1];
        sda_q     = sda_p[STAGES-1];
        scl_rise  = scl_q & ~scl_d;
        scl_fall  = ~scl_q & scl_d;
        start_det = scl_q & scl_d & sda_d & ~sda_q;
        stop_det  = scl_q & scl_d & ~sda_d & sda_q;
    end
endmodule

// File: rtl/i2crp_ptr.sv
// Memory address pointer: holds the increment flag and register address.
// Assumes load and step are never requested in the same cycle.
module i2crp_ptr #(
    parameter int         AW        = 7,
    parameter logic [7:0] RESET_VAL = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW:0]   load_val,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          incr
);
    // Pointer update: full load from a pointer byte, or +1 when flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            incr <= RESET_VAL[AW];
            addr <= RESET_VAL[AW-1:0];
        end else if (load) begin
            incr <= load_val[AW];
            addr <= load_val[AW-1:0];
        end else if (step && incr) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/i2crp_fsm.sv
// Bit/byte engine of the slave: shifts bytes in on SCL rise, drives SDA on SCL
// fall, acknowledges, and issues pointer and register requests.
// Assumes reg_rdata is a combinational function of the pointer address.
module i2crp_fsm
    import i2crp_pkg::*;
#(
    parameter logic [5:0] DEV_PREFIX = 6'b100110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_pull,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              ptr_load,
    output logic              ptr_step,
    output logic [BYTE_W-1:0] ptr_val,
    output st_t               st
);
    logic [2:0]        bit_cnt;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rd_xfer;
    logic              m_ack;
    logic              rx_state;

    // Pointer requests: load at the end of the pointer byte, step on master
    // ACK in reads or at the end of each write acknowledge.
    always_comb begin
        rx_state = (st == ST_ADDR) || (st == ST_PTR) || (st == ST_WDATA);
        ptr_val  = rx_sh;
        ptr_load = (st == ST_PTR) && scl_fall && byte_done;
        ptr_step = ((st == ST_RACK) && scl_rise && !sda_q) ||
                   ((st == ST_WDATA_ACK) && scl_fall);
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rd_xfer   <= 1'b0;
            m_ack     <= 1'b0;
            sda_pull  <= 1'b0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= 1'b0;
            if (start_det) begin
                st        <= ST_ADDR;
                bit_cnt   <= '0;
                byte_done <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (stop_det) begin
                st        <= ST_IDLE;
                byte_done <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise) begin
                    rx_sh   <= {rx_sh[BYTE_W-2:0], sda_q};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == 3'd7) byte_done <= 1'b1;
                end else if (scl_fall && byte_done) begin
                    byte_done <= 1'b0;
                    case (st)
                        ST_ADDR: begin
                            if (rx_sh[7:1] == {DEV_PREFIX, addr_sel}) begin
                                rd_xfer  <= rx_sh[0];
                                sda_pull <= 1'b1;
                                st       <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_PTR: begin
                            sda_pull <= 1'b1;
                            st       <= ST_PTR_ACK;
                        end
                        default: begin
                            sda_pull  <= 1'b1;
                            reg_wr    <= 1'b1;
                            reg_wdata <= rx_sh;
                            st        <= ST_WDATA_ACK;
                        end
                    endcase
                end
            end else begin
                case (st)
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_xfer) begin
                                tx_sh    <= reg_rdata;
                                sda_pull <= ~reg_rdata[BYTE_W-1];
                                st       <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            bit_cnt  <= '0;
                            sda_pull <= 1'b0;
                            st       <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) byte_done <= 1'b1;
                        end else if (scl_fall) begin
                            if (byte_done) begin
                                byte_done <= 1'b0;
                                sda_pull  <= 1'b0;
                                st        <= ST_RACK;
                            end else begin
                                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_q;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                bit_cnt  <= '0;
                                tx_sh    <= reg_rdata;
                                sda_pull <= ~reg_rdata[BYTE_W-1];
                                st       <= ST_RDATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regport.sv
// Top of the I2C register-port slave. Wires the line synchroniser, the
// protocol engine and the pointer; the register bank lives outside.
// Assumes an external open-drain pad turns sda_pull into a low on SDA.
module i2c_regport
    import i2crp_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_PREFIX  = 6'b100110,
    parameter logic [7:0] PTR_RESET   = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              addr_sel,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic              scl_q;
    logic              sda_q;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ptr_load;
    logic              ptr_step;
    logic [BYTE_W-1:0] ptr_val;
    logic              ptr_incr;
    logic              in_idle;
    st_t               st;

    i2crp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2crp_fsm #(.DEV_PREFIX(DEV_PREFIX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .reg_rdata(reg_rdata), .sda_pull(sda_pull),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .ptr_load(ptr_load),
        .ptr_step(ptr_step), .ptr_val(ptr_val), .st(st)
    );

    i2crp_ptr #(.AW(PTR_W), .RESET_VAL(PTR_RESET)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_val),
        .step(ptr_step), .addr(reg_addr), .incr(ptr_incr)
    );

    // Idle flag exposed for the bound checker.
    assign in_idle = (st == ST_IDLE);
endmodule

// File: rtl/i2crp_chk.sv
// Protocol checker for i2c_regport, attached through bind.
module i2crp_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_q,
    input logic          sda_pull,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic          ptr_load,
    input logic          in_idle
);
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R4
    AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> sda_pull); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> (!sda_pull && !reg_wr)); // R2
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_q); // R6
    AST_PTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(reg_addr) && !$past(ptr_load)) |->
        (reg_addr == AW'($past(reg_addr) + 1'b1))); // R5
endmodule

bind i2c_regport i2crp_chk #(.AW(i2crp_pkg::PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_pull(sda_pull),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .ptr_load(ptr_load),
    .in_idle(in_idle)
);

// File: tb/sim_i2c_regport.sv
module sim_i2c_regport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b1;
    logic       sda_pull;
    logic       sda_line;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_wr;
    logic [7:0] reg_rdata;
    logic [7:0] mem   [128];
    logic [7:0] exp_m [128];
    logic       exp_incr;
    logic [6:0] exp_pa;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull;
    assign reg_rdata = mem[reg_addr];

    i2c_regport u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .addr_sel(strap), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
    );

    // Register bank model driven only by the block's write port.
    always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 29 + 7);
    endfunction

    function automatic logic [7:0] dev_byte(logic s, logic rw);
        return {6'b100110, s, rw};
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic w(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_bit(logic b);
        sda_m = b; w(4); scl = 1'b1; w(8); scl = 1'b0; w(4);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; w(4); scl = 1'b1; w(4);
        @(negedge clk); b = sda_line;
        w(4); scl = 1'b0; w(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(4); scl = 1'b1; w(8); sda_m = 1'b0; w(8);
        scl = 1'b0; w(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(4); scl = 1'b1; w(8); sda_m = 1'b1; w(8);
    endtask

    task automatic send_byte(logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic cmp_bank(string req);
        int bad = -1;
        for (int i = 0; i < 128; i++) if (mem[i] !== exp_m[i] && bad < 0) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, mem[bad], exp_m[bad]);
    endtask

    // Write transfer: pointer byte then n data bytes starting at seed value.
    task automatic wr_txn(logic [7:0] pb, int n, logic [7:0] seed);
        logic ack;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), ack);
        chk(ack, "R1 write address ack", ack, 1);
        send_byte(pb, ack);
        chk(ack, "R3 pointer byte ack", ack, 1);
        exp_incr = pb[7];
        exp_pa   = pb[6:0];
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = seed + 8'(k * 53);
            send_byte(d, ack);
            chk(ack, "R4 data byte ack", ack, 1);
            exp_m[exp_pa] = d;
            if (exp_incr) exp_pa = exp_pa + 7'd1;
        end
        bus_stop();
        cmp_bank(exp_incr ? "R5 incrementing write" : "R4 R5 fixed-register write");
    endtask

    // Read transfer, optionally preceded by a pointer write and repeated START.
    task automatic rd_txn(bit setp, logic [7:0] pb, int n, string tag);
        logic ack;
        logic [7:0] v;
        bus_start();
        if (setp) begin
            send_byte(dev_byte(strap, 1'b0), ack);
            chk(ack, "R1 address ack", ack, 1);
            send_byte(pb, ack);
            chk(ack, "R3 pointer ack", ack, 1);
            exp_incr = pb[7];
            exp_pa   = pb[6:0];
            bus_start();
        end
        send_byte(dev_byte(strap, 1'b1), ack);
        chk(ack, "R1 R10 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k < n - 1);
            chk(v == exp_m[exp_pa], tag, v, exp_m[exp_pa]);
            if (exp_incr && k < n - 1) exp_pa = exp_pa + 7'd1;
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 128; i++) begin
            mem[i]   = init_val(i);
            exp_m[i] = init_val(i);
        end
        exp_incr = 1'b0;
        exp_pa   = 7'h01;
        w(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sda_pull && !reg_wr, "R7 reset outputs", {sda_pull, reg_wr}, 0);
        chk(reg_addr == 7'h01, "R7 reset pointer", reg_addr, 1);

        // R7: read before any pointer write uses the default register.
        rd_txn(1'b0, 8'h00, 2, "R7 R8 default pointer read");

        // R2: wrong strap bit, then data bytes must not land anywhere.
        bus_start();
        send_byte(dev_byte(~strap, 1'b0), ack);
        chk(!ack, "R2 mismatched address nack", ack, 0);
        send_byte(8'h05, ack);
        chk(!ack, "R2 no ack after mismatch", ack, 0);
        recv_byte(v, 1'b0);
        chk(v == 8'hFF, "R2 SDA released after mismatch", v, 8'hFF);
        bus_stop();
        cmp_bank("R2 no write after mismatch");
        bus_start();
        send_byte(8'hA0, ack);
        chk(!ack, "R2 foreign address nack", ack, 0);
        bus_stop();

        // R5: wrap of the incrementing pointer at the top of the bank.
        wr_txn(8'hFE, 3, 8'h11);
        chk(reg_addr == 7'h01, "R5 pointer after wrap", reg_addr, 1);
        // R4: fixed-register write keeps the last byte.
        wr_txn(8'h10, 3, 8'h40);
        // R6: persistent pointer, no pointer write before the read.
        rd_txn(1'b0, 8'h00, 1, "R6 pointer kept across transfers");
        // R8: incrementing and fixed reads after a repeated START.
        rd_txn(1'b1, 8'h85, 4, "R8 R10 incrementing read");
        rd_txn(1'b1, 8'h22, 3, "R8 fixed read repeats register");

        // R9: after a master NACK the slave stays off the bus.
        rd_txn(1'b1, 8'h30, 1, "R6 single read");
        bus_start();
        send_byte(dev_byte(strap, 1'b1), ack);
        recv_byte(v, 1'b0);
        chk(v == exp_m[exp_pa], "R6 read before nack", v, exp_m[exp_pa]);
        recv_byte(v, 1'b0);
        chk(v == 8'hFF, "R9 released after nack", v, 8'hFF);
        bus_stop();

        // Randomised mix of transfers.
        for (int it = 0; it < 40; it++) begin
            logic [7:0] pb;
            int n;
            pb = 8'($urandom);
            n  = 1 + int'($urandom % 4);
            if ($urandom % 2) wr_txn(pb, n, 8'($urandom));
            else rd_txn(($urandom % 2) == 1, pb, n, "R6 R8 random read");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule